// File: doc/BRIEF.md
# SD/MMC Host Status and Interrupt Register Bank

This block holds the software-visible configuration and status state of an SD/MMC host controller. A 16-bit register port reads and writes it by byte offset. The port stores the 32-bit command argument, the control word, the event status word, the interrupt enables and the FIFO buffer configuration. Every stored field is also driven straight out to the command, clock and FIFO units that use it.

Those units report events by pulsing bits of `evt_set`. Each pulse sets the matching status bit, and software clears status bits by writing ones to them. A synchronous card-detect level sets a dedicated status bit when it rises. A single level interrupt is raised whenever an enabled status bit is pending. If the control word is written with the enable bit low, the block soft-resets the status word and sends a one-cycle flush request to the FIFO.

Top module: `sdh_regbank`

## Requirements
- R1: `irq` is high exactly when at least one bit of (status AND interrupt-enable) is set, and follows the stored registers with no added cycle.
- R2: A write to offset 0x10 (status) clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R3: Offset 0x14 (interrupt-enable) stores bits 14:0 of the written value, and its bit 15 always reads 0.
- R4: The command argument is written in halves: offset 0x04 holds bits 15:0 and offset 0x08 holds bits 31:16. Each write changes only its own half, and `cmd_arg` presents the full word.
- R5: Offset 0x0C (control) holds bus width in bit 15, transfer mode in bits 13:12, enable in bit 11, byte order in bit 10 and the clock divider in the low bits. The divider is 10 bits wide when `WIDE_DIV`=1 and 8 bits wide otherwise. Bit 14 and any divider bits above that width read 0.
- R6: A control write with bit 11 = 0 clears the whole status word. On the following cycle `fifo_flush` is high for exactly one cycle.
- R7: A low-to-high change of `card_det` sets status bit 1 on the next cycle. A steady level or a falling edge sets nothing.
- R8: Offset 0x18 (buffer) holds receive-DMA enable in bit 15, the almost-full level in bits 12:8, transmit-DMA enable in bit 7 and the almost-empty level in bits 4:0. A write with bit 15 set clears status bit 10, and a write with bit 7 set clears status bit 11.
- R9: After reset the buffer register reads 0x1F00, every other register reads 0, and `irq` and `fifo_flush` are low.
- R10: Offset 0x1C is a read-only revision word (2 when `WIDE_DIV`=1, else 1). Writes to it and to any undefined offset change nothing. Reads of undefined offsets return 0.
- R11: A one on `evt_set[i]` sets status bit i on the next cycle. Status reads back at offset 0x10.
- R12: When a set pulse and any clear source (status write, soft reset, DMA-enable clear) hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| evt_set | input | 16 | One-cycle pulses that set status bits |
| card_det | input | 1 | Synchronous card-present level |
| irq | output | 1 | Level interrupt request |
| cmd_arg | output | 32 | Command argument |
| bus_wide | output | 1 | Wide data bus selected |
| xfer_mode | output | 2 | Transfer mode field |
| host_en | output | 1 | Host enable |
| big_endian | output | 1 | Byte order select |
| clk_div | output | DIV_W | Card clock divider |
| rx_dma_en | output | 1 | Receive DMA request enable |
| tx_dma_en | output | 1 | Transmit DMA request enable |
| af_level | output | LVL_W | FIFO almost-full threshold |
| ae_level | output | LVL_W | FIFO almost-empty threshold |
| fifo_flush | output | 1 | One-cycle FIFO empty request |

## Verification
The bench builds the block with its defaults, `WIDE_DIV`=1 and `ADDR_W`=8. The full 10-bit divider path and the revision value 2 are therefore checked, and every offset in the 8-bit space can be decoded. The small status width lets the bench sweep every one of the 16 status bits through set, write-one-clear and interrupt gating. It also drives set and clear into the same bit in the same cycle, for both the status write and the DMA-enable clear.

// File: rtl/sdh_reg_pkg.sv
// Package: shared offsets, bit positions and the register index type
// for the SD/MMC host register bank. Assumes byte offsets on a 16-bit port.
package sdh_reg_pkg;

    localparam int BUS_W = 16;

    typedef enum logic [2:0] {
        RI_NONE,
        RI_ARGL,
        RI_ARGH,
        RI_CTRL,
        RI_STAT,
        RI_IEN,
        RI_BUF,
        RI_REV
    } reg_idx_e;

    localparam logic [7:0] OFF_ARGL = 8'h04;
    localparam logic [7:0] OFF_ARGH = 8'h08;
    localparam logic [7:0] OFF_CTRL = 8'h0C;
    localparam logic [7:0] OFF_STAT = 8'h10;
    localparam logic [7:0] OFF_IEN  = 8'h14;
    localparam logic [7:0] OFF_BUF  = 8'h18;
    localparam logic [7:0] OFF_REV  = 8'h1C;

    // Status bit positions fixed by neighbouring units
    localparam int ST_CDET   = 1;
    localparam int ST_AFULL  = 10;
    localparam int ST_AEMPTY = 11;

    // Control field positions
    localparam int CT_WIDE = 15;
    localparam int CT_MODE = 12;
    localparam int CT_EN   = 11;
    localparam int CT_BE   = 10;

    // Buffer field positions
    localparam int BF_RXDMA = 15;
    localparam int BF_AF    = 8;
    localparam int BF_TXDMA = 7;
    localparam int BF_AE    = 0;

    // Map an offset to a register index; unknown offsets give RI_NONE.
    function automatic reg_idx_e map_offset(input logic [7:0] off);
        case (off)
            OFF_ARGL: map_offset = RI_ARGL;
            OFF_ARGH: map_offset = RI_ARGH;
            OFF_CTRL: map_offset = RI_CTRL;
            OFF_STAT: map_offset = RI_STAT;
            OFF_IEN:  map_offset = RI_IEN;
            OFF_BUF:  map_offset = RI_BUF;
            OFF_REV:  map_offset = RI_REV;
            default:  map_offset = RI_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sdh_reg_decode.sv
// Module: address decoder. Turns a byte offset into a register index
// and one-hot write strobes. Assumes bus_addr wider than the offset
// space is out of range unless its upper bits are zero.
module sdh_reg_decode
    import sdh_reg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_idx_e          rd_idx,
    output logic              wr_argl,
    output logic              wr_argh,
    output logic              wr_ctrl,
    output logic              wr_stat,
    output logic              wr_ien,
    output logic              wr_buf
);
    localparam int OFF_W = 8;

    logic [OFF_W-1:0] off8;
    logic             in_range;

    // Fold the address down to the 8-bit offset space
    generate
        if (ADDR_W > OFF_W) begin : g_wide
            assign off8     = bus_addr[OFF_W-1:0];
            assign in_range = (bus_addr[ADDR_W-1:OFF_W] == '0);
        end else begin : g_narrow
            assign off8     = OFF_W'(bus_addr);
            assign in_range = 1'b1;
        end
    endgenerate

    // Select the register and qualify write strobes
    always_comb begin
        rd_idx  = in_range ? map_offset(off8) : RI_NONE;
        wr_argl = bus_wr && (rd_idx == RI_ARGL);
        wr_argh = bus_wr && (rd_idx == RI_ARGH);
        wr_ctrl = bus_wr && (rd_idx == RI_CTRL);
        wr_stat = bus_wr && (rd_idx == RI_STAT);
        wr_ien  = bus_wr && (rd_idx == RI_IEN);
        wr_buf  = bus_wr && (rd_idx == RI_BUF);
    end

endmodule

// File: rtl/sdh_reg_config.sv
// Module: configuration registers (argument, control, interrupt enable,
// buffer) plus the one-cycle FIFO flush request. Assumes write strobes
// are one-hot and last one cycle.
module sdh_reg_config
    import sdh_reg_pkg::*;
#(
    parameter int DIV_W = 10,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_argl,
    input  logic             wr_argh,
    input  logic             wr_ctrl,
    input  logic             wr_ien,
    input  logic             wr_buf,
    input  logic [BUS_W-1:0] wdata,
    output logic [2*BUS_W-1:0] arg,
    output logic             bus_wide,
    output logic [1:0]       xfer_mode,
    output logic             host_en,
    output logic             big_endian,
    output logic [DIV_W-1:0] clk_div,
    output logic [BUS_W-1:0] ien,
    output logic             rx_dma_en,
    output logic             tx_dma_en,
    output logic [LVL_W-1:0] af_level,
    output logic [LVL_W-1:0] ae_level,
    output logic             soft_rst,
    output logic             fifo_flush
);
    localparam logic [LVL_W-1:0] AF_RESET = '1;

    // A control write with the enable bit low requests a soft reset
    assign soft_rst = wr_ctrl && !wdata[CT_EN];

    // Argument halves, each written independently
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg <= '0;
        end else begin
            if (wr_argl) arg[BUS_W-1:0]       <= wdata;
            if (wr_argh) arg[2*BUS_W-1:BUS_W] <= wdata;
        end
    end

    // Control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_wide   <= 1'b0;
            xfer_mode  <= 2'b00;
            host_en    <= 1'b0;
            big_endian <= 1'b0;
            clk_div    <= '0;
        end else if (wr_ctrl) begin
            bus_wide   <= wdata[CT_WIDE];
            xfer_mode  <= wdata[CT_MODE+1:CT_MODE];
            host_en    <= wdata[CT_EN];
            big_endian <= wdata[CT_BE];
            clk_div    <= wdata[DIV_W-1:0];
        end
    end

    // Interrupt enables; the top bit is never stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= '0;
        end else if (wr_ien) begin
            ien <= {1'b0, wdata[BUS_W-2:0]};
        end
    end

    // Buffer configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_dma_en <= 1'b0;
            tx_dma_en <= 1'b0;
            af_level  <= AF_RESET;
            ae_level  <= '0;
        end else if (wr_buf) begin
            rx_dma_en <= wdata[BF_RXDMA];
            tx_dma_en <= wdata[BF_TXDMA];
            af_level  <= wdata[BF_AF+LVL_W-1:BF_AF];
            ae_level  <= wdata[BF_AE+LVL_W-1:BF_AE];
        end
    end

    // One-cycle flush request following a soft reset
    always_ff @(posedge clk) begin
        if (!rst_n) fifo_flush <= 1'b0;
        else        fifo_flush <= soft_rst;
    end

    // R4
    arg_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_argl && !wr_argh) |=> (arg[2*BUS_W-1:BUS_W] == $past(arg[2*BUS_W-1:BUS_W])));

    // R4
    arg_lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_argh && !wr_argl) |=> (arg[BUS_W-1:0] == $past(arg[BUS_W-1:0])));

    // R6
    flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_flush && !soft_rst) |=> !fifo_flush);

endmodule

// File: rtl/sdh_edge_rise.sv
// Module: rising-edge detector for a level that is already synchronous
// to clk. During reset the history follows the input, so a level that
// is high at reset release is not taken as an edge.
module sdh_edge_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_q;

    // Remember the previous level
    always_ff @(posedge clk) begin
        prev_q <= level;
    end

    assign rise = rst_n && level && !prev_q;

endmodule

// File: rtl/sdh_reg_status.sv
// Module: status word. Set pulses take priority over every clear source
// (write-one-clear, soft reset, DMA-enable clears). Assumes set pulses
// are synchronous to clk.
module sdh_reg_status
    import sdh_reg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] set_in,
    input  logic             cd_rise,
    input  logic             wr_stat,
    input  logic             soft_rst,
    input  logic             dma_clr_rx,
    input  logic             dma_clr_tx,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] status
);
    logic [BUS_W-1:0] set_vec;
    logic [BUS_W-1:0] clr_vec;

    // Gather set and clear sources
    always_comb begin
        set_vec = set_in;
        set_vec[ST_CDET] = set_in[ST_CDET] | cd_rise;
        clr_vec = '0;
        if (wr_stat)    clr_vec = clr_vec | wdata;
        if (soft_rst)   clr_vec = '1;
        if (dma_clr_rx) clr_vec[ST_AFULL]  = 1'b1;
        if (dma_clr_tx) clr_vec[ST_AEMPTY] = 1'b1;
    end

    // Update status with set winning over clear
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | set_vec;
    end

    // R2
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !soft_rst && !dma_clr_rx && !dma_clr_tx && set_in == '0 && !cd_rise)
        |=> (status == ($past(status) & ~$past(wdata))));

    // R6
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && set_in == '0 && !cd_rise) |=> (status == '0));

    // R8
    rx_dma_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_clr_rx && !set_in[ST_AFULL]) |=> !status[ST_AFULL]);

    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_in != '0) |=> ((status & $past(set_in)) == $past(set_in)));

endmodule

// File: rtl/sdh_regbank.sv
// Module: top of the SD/MMC host status and interrupt register bank.
// Joins the decoder, configuration registers, status word and the
// card-detect edge detector, and drives the read mux and interrupt.
// Assumes card_det is already synchronous to clk.
module sdh_regbank
    import sdh_reg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int WIDE_DIV = 1,
    parameter int LVL_W    = 5,
    localparam int DIV_W   = (WIDE_DIV != 0) ? 10 : 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [15:0]       evt_set,
    input  logic              card_det,
    output logic              irq,
    output logic [31:0]       cmd_arg,
    output logic              bus_wide,
    output logic [1:0]        xfer_mode,
    output logic              host_en,
    output logic              big_endian,
    output logic [DIV_W-1:0]  clk_div,
    output logic              rx_dma_en,
    output logic              tx_dma_en,
    output logic [LVL_W-1:0]  af_level,
    output logic [LVL_W-1:0]  ae_level,
    output logic              fifo_flush
);
    localparam logic [BUS_W-1:0] REV_ID = (WIDE_DIV != 0) ? 16'd2 : 16'd1;

    reg_idx_e         rd_idx;
    logic             wr_argl, wr_argh, wr_ctrl, wr_stat, wr_ien, wr_buf;
    logic [BUS_W-1:0] ien;
    logic [BUS_W-1:0] status;
    logic             soft_rst;
    logic             cd_rise;

    sdh_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .rd_idx  (rd_idx),
        .wr_argl (wr_argl),
        .wr_argh (wr_argh),
        .wr_ctrl (wr_ctrl),
        .wr_stat (wr_stat),
        .wr_ien  (wr_ien),
        .wr_buf  (wr_buf)
    );

    sdh_reg_config #(.DIV_W(DIV_W), .LVL_W(LVL_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_argl   (wr_argl),
        .wr_argh   (wr_argh),
        .wr_ctrl   (wr_ctrl),
        .wr_ien    (wr_ien),
        .wr_buf    (wr_buf),
        .wdata     (bus_wdata),
        .arg       (cmd_arg),
        .bus_wide  (bus_wide),
        .xfer_mode (xfer_mode),
        .host_en   (host_en),
        .big_endian(big_endian),
        .clk_div   (clk_div),
        .ien       (ien),
        .rx_dma_en (rx_dma_en),
        .tx_dma_en (tx_dma_en),
        .af_level  (af_level),
        .ae_level  (ae_level),
        .soft_rst  (soft_rst),
        .fifo_flush(fifo_flush)
    );

    sdh_edge_rise u_cd (
        .clk  (clk),
        .rst_n(rst_n),
        .level(card_det),
        .rise (cd_rise)
    );

    sdh_reg_status u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_in    (evt_set),
        .cd_rise   (cd_rise),
        .wr_stat   (wr_stat),
        .soft_rst  (soft_rst),
        .dma_clr_rx(wr_buf && bus_wdata[BF_RXDMA]),
        .dma_clr_tx(wr_buf && bus_wdata[BF_TXDMA]),
        .wdata     (bus_wdata),
        .status    (status)
    );

    // Interrupt whenever an enabled status bit is pending
    assign irq = |(status & ien);

    // Read mux assembling each register from its fields
    always_comb begin
        bus_rdata = '0;
        case (rd_idx)
            RI_ARGL: bus_rdata = cmd_arg[15:0];
            RI_ARGH: bus_rdata = cmd_arg[31:16];
            RI_CTRL: begin
                bus_rdata[CT_WIDE]             = bus_wide;
                bus_rdata[CT_MODE+1:CT_MODE]   = xfer_mode;
                bus_rdata[CT_EN]               = host_en;
                bus_rdata[CT_BE]               = big_endian;
                bus_rdata[DIV_W-1:0]           = clk_div;
            end
            RI_STAT: bus_rdata = status;
            RI_IEN:  bus_rdata = ien;
            RI_BUF: begin
                bus_rdata[BF_RXDMA]            = rx_dma_en;
                bus_rdata[BF_AF+LVL_W-1:BF_AF] = af_level;
                bus_rdata[BF_TXDMA]            = tx_dma_en;
                bus_rdata[BF_AE+LVL_W-1:BF_AE] = ae_level;
            end
            RI_REV:  bus_rdata = REV_ID;
            default: bus_rdata = '0;
        endcase
    end

    // R7
    cdet_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_det) |=> status[ST_CDET]);

    // R1
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata == 16'hFFFF && evt_set == '0 && !cd_rise) |=> !irq);

    // R3
    ien_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ien |=> !ien[BUS_W-1]);

endmodule

// File: tb/tb_sdh_regbank.sv
// Bench: near-exhaustive sweeps of the register bank with a bench-side
// model of every register.
module tb_sdh_regbank;
    localparam int ADDR_W = 8;
    localparam int WIDE_DIV = 1;
    localparam int LVL_W = 5;
    localparam int DIV_W = (WIDE_DIV != 0) ? 10 : 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic [15:0]       evt_set = '0;
    logic              card_det = 1'b0;
    logic              irq;
    logic [31:0]       cmd_arg;
    logic              bus_wide, host_en, big_endian, rx_dma_en, tx_dma_en, fifo_flush;
    logic [1:0]        xfer_mode;
    logic [DIV_W-1:0]  clk_div;
    logic [LVL_W-1:0]  af_level, ae_level;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    sdh_regbank #(.ADDR_W(ADDR_W), .WIDE_DIV(WIDE_DIV), .LVL_W(LVL_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
        .card_det(card_det), .irq(irq), .cmd_arg(cmd_arg), .bus_wide(bus_wide),
        .xfer_mode(xfer_mode), .host_en(host_en), .big_endian(big_endian),
        .clk_div(clk_div), .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en),
        .af_level(af_level), .ae_level(ae_level), .fifo_flush(fifo_flush)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle with optional write and set pulses; inputs change at negedge
    task automatic cycle(input logic wr, input logic [7:0] a, input logic [15:0] d,
                         input logic [15:0] ev);
        bus_wr = wr; bus_addr = a; bus_wdata = d; evt_set = ev;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; evt_set = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        cycle(1'b1, a, d, 16'h0);
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] r;
        logic [15:0] acc;
        logic [15:0] ctl_mask;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset values
        rd(8'h04, r); check("R9 argl", r, 0);
        rd(8'h08, r); check("R9 argh", r, 0);
        rd(8'h0C, r); check("R9 ctrl", r, 0);
        rd(8'h10, r); check("R9 stat", r, 0);
        rd(8'h14, r); check("R9 ien", r, 0);
        rd(8'h18, r); check("R9 buf", r, 16'h1F00);
        check("R9 irq", irq, 0);
        check("R9 flush", fifo_flush, 0);

        // R4 argument halves
        wr(8'h04, 16'hBEEF);
        check("R4 arg low", cmd_arg, 32'h0000BEEF);
        wr(8'h08, 16'hCAFE);
        check("R4 arg both", cmd_arg, 32'hCAFEBEEF);
        wr(8'h04, 16'h1234);
        check("R4 arg high kept", cmd_arg, 32'hCAFE1234);
        rd(8'h08, r); check("R4 argh read", r, 16'hCAFE);

        // R5 control layout, enable kept high
        ctl_mask = 16'hBC00 | 16'((1 << DIV_W) - 1);
        wr(8'h0C, 16'hFFFF);
        rd(8'h0C, r); check("R5 ctrl all ones", r, ctl_mask);
        check("R5 div", clk_div, (1 << DIV_W) - 1);
        check("R5 mode", xfer_mode, 3);
        wr(8'h0C, 16'h9A5A);
        rd(8'h0C, r); check("R5 ctrl pattern", r, 16'h9A5A & ctl_mask);
        check("R5 fields", {bus_wide, host_en, big_endian}, {1'b1, 1'b1, 1'b0});

        // R11 set sweep over every status bit
        acc = 0;
        for (int i = 0; i < 16; i++) begin
            cycle(1'b0, 8'h10, 16'h0, 16'(1 << i));
            acc = acc | 16'(1 << i);
            rd(8'h10, r); check("R11 set bit", r, acc);
        end
        // R2 write-one-clear
        wr(8'h10, 16'h5555);
        rd(8'h10, r); check("R2 w1c half", r, 16'hAAAA);
        wr(8'h10, 16'h0000);
        rd(8'h10, r); check("R2 zero write", r, 16'hAAAA);
        wr(8'h10, 16'hAAAA);
        rd(8'h10, r); check("R2 w1c rest", r, 16'h0000);

        // R3 interrupt enable top bit
        wr(8'h14, 16'hFFFF);
        rd(8'h14, r); check("R3 ien", r, 16'h7FFF);

        // R1 interrupt gating sweep
        for (int i = 0; i < 16; i++) begin
            wr(8'h14, 16'(1 << i));
            cycle(1'b0, 8'h10, 16'h0, ~16'(1 << i));
            check("R1 irq other bits", irq, 0);
            cycle(1'b0, 8'h10, 16'h0, 16'(1 << i));
            check("R1 irq own bit", irq, (i != 15));
            wr(8'h10, 16'hFFFF);
            check("R1 irq cleared", irq, 0);
        end

        // R12 set wins over status write
        cycle(1'b1, 8'h10, 16'h0008, 16'h0008);
        rd(8'h10, r); check("R12 set over w1c", r, 16'h0008);
        wr(8'h10, 16'hFFFF);

        // R8 buffer layout and DMA-enable clears
        cycle(1'b0, 8'h10, 16'h0, 16'h0C00);
        wr(8'h18, 16'h8500);
        rd(8'h10, r); check("R8 rx dma clears bit10", r, 16'h0800);
        rd(8'h18, r); check("R8 buf read", r, 16'h8500);
        check("R8 af level", af_level, 5);
        wr(8'h18, 16'h0083);
        rd(8'h10, r); check("R8 tx dma clears bit11", r, 16'h0000);
        check("R8 dma enables", {rx_dma_en, tx_dma_en, ae_level}, {1'b0, 1'b1, 5'd3});
        cycle(1'b1, 8'h18, 16'h8000, 16'h0400);
        rd(8'h10, r); check("R12 set over dma clear", r, 16'h0400);

        // R6 soft reset via control enable low
        cycle(1'b0, 8'h10, 16'h0, 16'h7003);
        bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 16'h0000;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R6 flush pulse", fifo_flush, 1);
        rd(8'h10, r); check("R6 status cleared", r, 0);
        @(negedge clk);
        check("R6 flush single", fifo_flush, 0);

        // R7 card detect
        card_det = 1'b1;
        @(negedge clk);
        rd(8'h10, r); check("R7 rise sets bit1", r, 16'h0002);
        wr(8'h10, 16'h0002);
        repeat (3) @(negedge clk);
        rd(8'h10, r); check("R7 steady high", r, 0);
        card_det = 1'b0;
        repeat (2) @(negedge clk);
        rd(8'h10, r); check("R7 fall", r, 0);

        // R10 read-only and undefined offsets
        wr(8'h14, 16'h0123);
        wr(8'h1C, 16'hFFFF);
        wr(8'h00, 16'hFFFF);
        wr(8'h05, 16'hFFFF);
        wr(8'h20, 16'hFFFF);
        wr(8'hFC, 16'hFFFF);
        rd(8'h1C, r); check("R10 revision", r, (WIDE_DIV != 0) ? 2 : 1);
        rd(8'h00, r); check("R10 undef read 00", r, 0);
        rd(8'h05, r); check("R10 undef read 05", r, 0);
        rd(8'hFC, r); check("R10 undef read FC", r, 0);
        rd(8'h10, r); check("R10 stat untouched", r, 0);
        rd(8'h14, r); check("R10 ien untouched", r, 16'h0123);
        rd(8'h18, r); check("R10 buf untouched", r, 16'h8000);
        check("R10 arg untouched", cmd_arg, 32'hCAFE1234);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule